// File: doc/BRIEF.md
# Data Alignment and Access Checker

This block sits next to a load/store unit and judges every data access request as it is issued. For each request it decides whether the access is misaligned under the current alignment-checking policy, or whether it is a supervisor-level access to a user page that protection forbids. The verdict is registered and appears one clock after the request strobe.

Alignment checking turns on only when three conditions hold together: the control-register alignment enable, the alignment/override flag in the flags word, and user privilege (level 3). References that the hardware makes implicitly at privilege 0 are exempt. The same flag in the flags word also acts as the override that lets an explicit supervisor data access reach a user page while protection is on. Implicit supervisor references get no such override.

Top module: `data_access_checker`

## Requirements
- R1: While reset (synchronous, active low) is asserted, and on the first cycle after it, fault_valid is 0 and fault_code is 0.
- R2: The verdict for a request with req_valid=1 appears on the outputs on the clock after it. A cycle with req_valid=0 yields fault_valid=0 and fault_code=0 on the next clock.
- R3: req_size encodes the operand as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A 1-byte operand never raises an alignment fault.
- R4: With alignment checking active, a 2-byte operand at an odd address (req_addr[0]=1) raises an alignment fault.
- R5: With alignment checking active, a 4-byte operand with req_addr[1:0] not 0 raises an alignment fault.
- R6: With alignment checking active, an 8-byte operand with req_addr[2:0] not 0 raises an alignment fault.
- R7: Alignment checking is active only when cr_align_mask=1, bit 18 of flags_word is 1, and req_cpl=3. No other bit of flags_word has any effect.
- R8: A request with req_implicit=1 never raises an alignment fault.
- R9: With cr_prot_en=1, an explicit request (req_implicit=0) at req_cpl 0, 1 or 2 to a page with page_user=1 raises an access fault unless bit 18 of flags_word is 1.
- R10: With cr_prot_en=1, an implicit request at req_cpl 0, 1 or 2 to a user page raises an access fault whatever bit 18 holds.
- R11: No access fault is raised when cr_prot_en=0, when page_user=0, or when req_cpl=3.
- R12: fault_code is 0 for no fault, 1 for an alignment fault and 2 for an access fault. An access fault takes precedence over an alignment fault. fault_valid is 1 exactly when fault_code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe for this cycle |
| req_addr | input | ADDR_W (32) | Access byte address |
| req_size | input | 2 | Operand size code (0..3 = 1, 2, 4, 8 bytes) |
| req_cpl | input | 2 | Current privilege level |
| req_implicit | input | 1 | 1 = implicit privileged reference, 0 = explicit data access |
| page_user | input | 1 | 1 = target page is a user page |
| cr_align_mask | input | 1 | Control-register alignment-check enable |
| cr_prot_en | input | 1 | Control-register supervisor access protection enable |
| flags_word | input | FLAGS_W (32) | Flags register; bit 18 is the alignment/override flag |
| fault_valid | output | 1 | Registered: a fault was found for the last request |
| fault_code | output | 2 | Registered fault code (0 none, 1 alignment, 2 access) |

## Verification
The hardest case to reach from the ports is an alignment check that is nearly active but held off by one missing condition. Examples are a misaligned 8-byte access at privilege 3 with the flag clear, or an implicit reference with every enable set. Reaching these takes the right combination of privilege, enables, flag and low address bits all at once. The stimulus therefore sweeps every combination of operand size, the three low address bits, privilege level, implicit flag, page type, both enables and the override flag. It varies the upper address bits and the other flags-word bits between requests, and it inserts idle cycles between requests so that the clearing behaviour is observed each time.

// File: rtl/dac_pkg.sv
// Package: shared types and constants for the data access checker.
// Assumes the alignment/override flag position is fixed for all instances.
package dac_pkg;
    localparam int SIZE_W   = 2;
    localparam int CPL_W    = 2;
    localparam int LOW_BITS = 3;   // enough to test an 8-byte boundary
    localparam int FLAG_AC  = 18;  // override / alignment flag position

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_ALIGN  = 2'd1,
        FC_ACCESS = 2'd2
    } fault_code_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } op_size_t;

    localparam logic [CPL_W-1:0] CPL_USER = 2'd3;
endpackage

// File: rtl/dac_align_check.sv
// Module: dac_align_check
// Decides whether a request is misaligned under the current policy.
// Assumes size code n means 2**n bytes and the largest operand is 8 bytes.
module dac_align_check
    import dac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [CPL_W-1:0]  cpl,
    input  logic              implicit_ref,
    input  logic              mask_en,
    input  logic              ac_flag,
    output logic              align_fault
);
    logic [LOW_BITS-1:0] low_mask;
    logic                check_on;
    logic                misaligned;

    // Build the low-address mask for each size code, one bit per position.
    for (genvar b = 0; b < LOW_BITS; b++) begin : g_mask
        assign low_mask[b] = (int'(size) > b);
    end

    // Checking needs all three qualifiers and an explicit reference.
    always_comb begin
        check_on    = mask_en && ac_flag && (cpl == CPL_USER) && !implicit_ref;
        misaligned  = |(addr[LOW_BITS-1:0] & low_mask);
        align_fault = check_on && misaligned;
    end
endmodule

// File: rtl/dac_protect_check.sv
// Module: dac_protect_check
// Flags supervisor-level data accesses to user pages when protection is on.
// Assumes privilege levels 0..2 are supervisor and 3 is user.
module dac_protect_check
    import dac_pkg::*;
(
    input  logic             prot_en,
    input  logic             page_user,
    input  logic [CPL_W-1:0] cpl,
    input  logic             implicit_ref,
    input  logic             ac_flag,
    output logic             access_fault
);
    logic supervisor;
    logic override_ok;

    // Explicit accesses may be let through by the flag; implicit ones never.
    always_comb begin
        supervisor   = (cpl != CPL_USER);
        override_ok  = ac_flag && !implicit_ref;
        access_fault = prot_en && page_user && supervisor && !override_ok;
    end
endmodule

// File: rtl/dac_fault_reg.sv
// Module: dac_fault_reg
// Prioritises the two fault sources and registers the verdict.
// Assumes the strobe qualifies the inputs; an idle cycle clears the output.
module dac_fault_reg
    import dac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        align_fault,
    input  logic        access_fault,
    output logic        fault_valid,
    output fault_code_t fault_code
);
    fault_code_t next_code;
    logic        next_valid;

    // Access faults outrank alignment faults.
    always_comb begin
        next_code  = FC_NONE;
        next_valid = 1'b0;
        if (req_valid) begin
            if (access_fault) begin
                next_code  = FC_ACCESS;
                next_valid = 1'b1;
            end else if (align_fault) begin
                next_code  = FC_ALIGN;
                next_valid = 1'b1;
            end
        end
    end

    // Hold the verdict for one cycle; synchronous reset gives no fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_code  <= FC_NONE;
            fault_valid <= 1'b0;
        end else begin
            fault_code  <= next_code;
            fault_valid <= next_valid;
        end
    end
endmodule

// File: rtl/data_access_checker.sv
// Module: data_access_checker (top)
// Judges each load/store request for alignment and access-protection faults
// and reports the verdict one clock later. Assumes flags_word is stable in the
// request cycle and that the override flag sits at FLAG_AC.
module data_access_checker
    import dac_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FLAGS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [1:0]         req_cpl,
    input  logic               req_implicit,
    input  logic               page_user,
    input  logic               cr_align_mask,
    input  logic               cr_prot_en,
    input  logic [FLAGS_W-1:0] flags_word,
    output logic               fault_valid,
    output logic [1:0]         fault_code
);
    logic        ac_flag;
    logic        align_fault;
    logic        access_fault;
    fault_code_t code_q;

    // Pick the override/alignment flag out of the flags word.
    assign ac_flag = flags_word[FLAG_AC];

    dac_align_check #(.ADDR_W(ADDR_W)) u_align (
        .addr         (req_addr),
        .size         (req_size),
        .cpl          (req_cpl),
        .implicit_ref (req_implicit),
        .mask_en      (cr_align_mask),
        .ac_flag      (ac_flag),
        .align_fault  (align_fault)
    );

    dac_protect_check u_prot (
        .prot_en      (cr_prot_en),
        .page_user    (page_user),
        .cpl          (req_cpl),
        .implicit_ref (req_implicit),
        .ac_flag      (ac_flag),
        .access_fault (access_fault)
    );

    dac_fault_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .align_fault  (align_fault),
        .access_fault (access_fault),
        .fault_valid  (fault_valid),
        .fault_code   (code_q)
    );

    // Present the enum as a plain vector at the port.
    assign fault_code = code_q;
endmodule

// File: rtl/data_access_checker_sva.sv
// Module: data_access_checker_sva
// Checker bound to the top; relates registered outputs to the previous
// cycle's request inputs.
module data_access_checker_sva #(
    parameter int ADDR_W  = 32,
    parameter int FLAGS_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_size,
    input logic [1:0]         req_cpl,
    input logic               req_implicit,
    input logic               page_user,
    input logic               cr_align_mask,
    input logic               cr_prot_en,
    input logic [FLAGS_W-1:0] flags_word,
    input logic               fault_valid,
    input logic [1:0]         fault_code
);
    // An idle cycle leaves no fault behind (R2).
    assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (fault_code == 2'd0 && !fault_valid));

    // Byte operands never misalign (R3).
    assert_byte_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |=> (fault_code != 2'd1));

    // Alignment faults need every qualifier (R7, R8).
    assert_align_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'd1) |-> $past(cr_align_mask && flags_word[18]
                                       && req_cpl == 2'd3 && !req_implicit));

    // Access faults need protection, a user page and supervisor level (R11).
    assert_access_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'd2) |-> $past(cr_prot_en && page_user && req_cpl != 2'd3));

    // Implicit supervisor access to a user page is always blocked (R10).
    assert_implicit_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cr_prot_en && page_user && req_implicit && req_cpl != 2'd3)
        |=> (fault_code == 2'd2));

    // Valid flag agrees with the code; code 3 never appears (R12).
    assert_valid_matches_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid == (fault_code != 2'd0)) && (fault_code != 2'd3));
endmodule

bind data_access_checker data_access_checker_sva #(
    .ADDR_W (ADDR_W),
    .FLAGS_W(FLAGS_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_cpl      (req_cpl),
    .req_implicit (req_implicit),
    .page_user    (page_user),
    .cr_align_mask(cr_align_mask),
    .cr_prot_en   (cr_prot_en),
    .flags_word   (flags_word),
    .fault_valid  (fault_valid),
    .fault_code   (fault_code)
);

// File: tb/data_access_checker_bench.sv
// Bench: exhaustive sweep of every request attribute combination, with the
// expected verdict computed arithmetically from the requirements.
module data_access_checker_bench;
    localparam int ADDR_W  = 32;
    localparam int FLAGS_W = 32;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid;
    logic [ADDR_W-1:0]  req_addr;
    logic [1:0]         req_size;
    logic [1:0]         req_cpl;
    logic               req_implicit;
    logic               page_user;
    logic               cr_align_mask;
    logic               cr_prot_en;
    logic [FLAGS_W-1:0] flags_word;
    logic               fault_valid;
    logic [1:0]         fault_code;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    data_access_checker #(.ADDR_W(ADDR_W), .FLAGS_W(FLAGS_W)) u_data_access_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_cpl(req_cpl), .req_implicit(req_implicit),
        .page_user(page_user), .cr_align_mask(cr_align_mask),
        .cr_prot_en(cr_prot_en), .flags_word(flags_word),
        .fault_valid(fault_valid), .fault_code(fault_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_cpl = '0; req_implicit = 1'b0; page_user = 1'b0;
        cr_align_mask = 1'b0; cr_prot_en = 1'b0; flags_word = '0;
        // Drive a faulting request during reset: it must not show (R1).
        @(negedge clk);
        req_valid = 1'b1; cr_prot_en = 1'b1; page_user = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 code in reset", fault_code, 0);
        check("R1 valid in reset", fault_valid, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code after reset", fault_code, 0);
        check("R1 valid after reset", fault_valid, 0);

        for (int idx = 0; idx < 4096; idx++) begin
            automatic int sz   = idx & 3;
            automatic int lo   = (idx >> 2) & 7;
            automatic int cpl  = (idx >> 5) & 3;
            automatic int imp  = (idx >> 7) & 1;
            automatic int usr  = (idx >> 8) & 1;
            automatic int msk  = (idx >> 9) & 1;
            automatic int prot = (idx >> 10) & 1;
            automatic int ac   = (idx >> 11) & 1;
            automatic int acc_f, al_f, exp_code;
            automatic string tag;
            automatic logic [FLAGS_W-1:0] noise;

            acc_f = (prot == 1 && usr == 1 && cpl != 3 && (imp == 1 || ac == 0)) ? 1 : 0;
            al_f  = (msk == 1 && ac == 1 && cpl == 3 && imp == 0
                     && (lo % (1 << sz)) != 0) ? 1 : 0;
            exp_code = acc_f ? 2 : (al_f ? 1 : 0);

            if (acc_f)                         tag = imp ? "R10" : "R9";
            else if (al_f && sz == 1)          tag = "R4";
            else if (al_f && sz == 2)          tag = "R5";
            else if (al_f && sz == 3)          tag = "R6";
            else if (sz == 0)                  tag = "R3";
            else if (imp == 1 && cpl == 3)     tag = "R8";
            else if (prot == 1 && usr == 1 && cpl != 3) tag = "R9";
            else if (cpl == 3)                 tag = "R7";
            else                               tag = "R11";

            // Other flags-word bits vary; only bit 18 may matter (R7).
            noise = (32'hA5C3_0F69 ^ (idx * 32'h9E37)) & ~(32'h1 << 18);
            req_valid     = 1'b1;
            req_addr      = (ADDR_W'(idx) * 32'h0001_0040) | ADDR_W'(lo);
            req_addr[2:0] = 3'(lo);
            req_size      = 2'(sz);
            req_cpl       = 2'(cpl);
            req_implicit  = imp[0];
            page_user     = usr[0];
            cr_align_mask = msk[0];
            cr_prot_en    = prot[0];
            flags_word    = noise | (FLAGS_W'(ac) << 18);
            @(negedge clk);
            check(tag, fault_code, exp_code);
            check("R12 valid", fault_valid, exp_code != 0 ? 1 : 0);
            // Idle cycle with the same attributes: verdict must clear (R2).
            req_valid = 1'b0;
            @(negedge clk);
            check("R2 idle code", fault_code, 0);
            check("R2 idle valid", fault_valid, 0);
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule